// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps a small set of recent virtual-page-to-physical-page translations and answers a lookup in a single registered step. Every slot stores a virtual page number, an 8-bit address space identifier, a physical page number, a page-size mask and three control bits: valid, reference and dirty. A lookup presents a 32-bit virtual address, the identifier of the running address space and the access type. The response one cycle later is a hit, a miss or a modify exception, with the translated physical address.

Slots are filled through a command port in one of two ways. The first fills the slot held in an index register, which software loads beforehand. The second fills the slot that a free-running random register points at in that cycle. The random register counts down every cycle. It never goes below a fixed count of wired slots, so the lowest slots are safe from random replacement. A flush input drops every translation in one cycle. Walking page tables and servicing misses are left to the surrounding system.

Top module: `xlat_cache`

## Requirements
- R1: After reset no slot is valid, the lookup flags (`lkHit`, `lkMiss`, `lkModExc`, `lkMultiHit`) are low, and `curRandom` equals ENTRIES-1.
- R2: A lookup raised with `lkReq` gives its result in the cycle after the request. It hits only on a slot that is valid and whose ASID and unmasked VPN bits both equal the request. `lkPaddr` is then the slot's PPN above the 12 offset bits, which are copied from the virtual address.
- R3: A lookup that matches no valid slot sets `lkMiss` alone. This includes a slot with the right VPN under another ASID. Exactly one of `lkHit`, `lkMiss` and `lkModExc` is high in each response cycle, and none is high in any other cycle.
- R4: Bit k of a slot's 12-bit page mask (k = 0..11) marks virtual address bit 12+k as offset. A marked bit is left out of the VPN compare and is copied into the physical address in place of PPN bit k. A full mask gives 16 MB pages, whose compare covers only address bits 31..24.
- R5: A lookup that hits sets the reference bit of the winning slot. `rdRef` shows it for the slot chosen by `rdIdx`, and `rdValid` shows that slot's valid bit.
- R6: A write lookup (`lkWrite`=1) that matches a slot whose dirty bit is clear sets `lkModExc` instead of `lkHit`, and it does not set the slot's reference bit. A write to a dirty slot hits, and so does a read of a clean slot.
- R7: When more than one valid slot matches, the lowest-numbered slot supplies the result and `lkMultiHit` is set with it.
- R8: Command encoding on `wrCmd`: 0 idle, 1 write-indexed, 2 write-random, 3 load the index register from `wrIndex`. Write-indexed fills the slot named by the index register, whose value changes only on command 3.
- R9: Write-random fills the slot that `curRandom` shows in the cycle the command is presented.
- R10: `curRandom` drops by one every cycle. From the wired count WIRED (default 4) it wraps to ENTRIES-1, so it never goes below WIRED.
- R11: A one-cycle `flush` makes every slot invalid from the next cycle, so a lookup issued after it misses. If a fill arrives in the same cycle, the flush wins.
- R12: Filling a slot clears its reference bit. The slot's valid and dirty bits are taken from `wrValid` and `wrDirty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate all slots |
| lkReq | input | 1 | Lookup request |
| lkVaddr | input | 32 | Virtual address to translate |
| lkAsid | input | 8 | Address space identifier of the request |
| lkWrite | input | 1 | Access type: 1 write, 0 read |
| lkHit | output | 1 | Translation found |
| lkMiss | output | 1 | No valid slot matched |
| lkModExc | output | 1 | Write to a clean slot |
| lkMultiHit | output | 1 | More than one slot matched |
| lkPaddr | output | 32 | Translated physical address |
| wrCmd | input | 2 | Fill command (0 idle, 1 indexed, 2 random, 3 load index) |
| wrIndex | input | 5 | Value for the index register |
| wrVpn | input | 20 | VPN of the new slot |
| wrAsid | input | 8 | ASID of the new slot |
| wrPpn | input | 20 | PPN of the new slot |
| wrMask | input | 12 | Page-size mask of the new slot |
| wrValid | input | 1 | Valid bit of the new slot |
| wrDirty | input | 1 | Dirty bit of the new slot |
| rdIdx | input | 5 | Slot selected for inspection |
| rdValid | output | 1 | Valid bit of the inspected slot |
| rdRef | output | 1 | Reference bit of the inspected slot |
| curRandom | output | 5 | Current random register value |

## Verification
The assertions assume that `wrCmd` never names an out-of-range slot and that `lkReq` is a plain level with no timing of its own beyond the clock. They also assume that the response flags are judged only in the cycle after a request. The bench drives every input at the falling edge and holds `wrIndex` below ENTRIES. Each command and each lookup lasts exactly one cycle, with an idle cycle after it, so every response cycle belongs to a single request. Masks in the stimulus are contiguous runs of low ones, which are the only page sizes the compare logic is meant for.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // widest slot number the strobe can carry; ENTRIES must not exceed 2**SLOT_W
  localparam int SLOT_W = 8;

  typedef enum logic [1:0] {
    CMD_IDLE      = 2'd0,
    CMD_FILL_IDX  = 2'd1,
    CMD_FILL_RND  = 2'd2,
    CMD_LOAD_IDX  = 2'd3
  } fill_cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              fill;
    logic [SLOT_W-1:0] slot;
    logic              clear;
    logic              look;
  } xlat_stb_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int WIRED   = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             lkReq,
  input  logic [1:0]       wrCmd,
  input  logic [IDX_W-1:0] wrIndex,
  output xlat_stb_t        stb,
  output logic [IDX_W-1:0] curRandom
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(ENTRIES - 1);
  localparam logic [IDX_W-1:0] LOW_IDX = IDX_W'(WIRED);

  fill_cmd_e        cmd;
  logic [IDX_W-1:0] randReg;
  logic [IDX_W-1:0] idxReg;

  assign cmd = fill_cmd_e'(wrCmd);

  // free-running victim pointer, confined to the non-wired slots
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                randReg <= TOP_IDX;
    else if (randReg == LOW_IDX) randReg <= TOP_IDX;
    else                      randReg <= randReg - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    idxReg <= '0;
    else if (cmd == CMD_LOAD_IDX) idxReg <= wrIndex;
  end

  always_comb begin
    stb       = '0;
    stb.clear = flush;
    stb.look  = lkReq;
    stb.fill  = (cmd == CMD_FILL_IDX) || (cmd == CMD_FILL_RND);
    stb.slot  = (cmd == CMD_FILL_RND) ? SLOT_W'(randReg) : SLOT_W'(idxReg);
  end

  assign curRandom = randReg;

  // R10
  rand_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (randReg >= LOW_IDX) && (randReg <= TOP_IDX));

  // R10
  rand_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (randReg != LOW_IDX) |=> (randReg == $past(randReg) - 1'b1));

  // R8
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd != CMD_LOAD_IDX) |=> $stable(idxReg));
endmodule

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int ENTRIES  = 32,
  parameter int VA_W     = 32,
  parameter int PG_SHIFT = 12,
  parameter int ASID_W   = 8,
  parameter int PPN_W    = 20,
  parameter int MASK_W   = 12,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int VPN_W   = VA_W - PG_SHIFT,
  localparam int PA_W    = PPN_W + PG_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlat_stb_t         stb,
  input  logic [VA_W-1:0]   lkVaddr,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic              lkWrite,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic [PPN_W-1:0]  wrPpn,
  input  logic [MASK_W-1:0] wrMask,
  input  logic              wrValid,
  input  logic              wrDirty,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              rdValid,
  output logic              rdRef,
  output logic              lkHit,
  output logic              lkMiss,
  output logic              lkModExc,
  output logic              lkMultiHit,
  output logic [PA_W-1:0]   lkPaddr
);
  logic [VPN_W-1:0]  entVpn   [ENTRIES];
  logic [ASID_W-1:0] entAsid  [ENTRIES];
  logic [PPN_W-1:0]  entPpn   [ENTRIES];
  logic [MASK_W-1:0] entMask  [ENTRIES];
  logic              entDirty [ENTRIES];
  logic              entValid [ENTRIES];
  logic              entRef   [ENTRIES];
  logic [VPN_W-1:0]  cmpMask  [ENTRIES];

  logic [ENTRIES-1:0] matchVec;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] refVec;
  logic [VPN_W-1:0]   vaVpn;
  logic [IDX_W-1:0]   hitIdx;
  logic               anyMatch;
  logic               manyMatch;
  logic               cleanWrite;
  logic               hitNow;
  logic [PA_W-1:0]    paNow;

  assign vaVpn = lkVaddr[VA_W-1:PG_SHIFT];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic fillHere;
    assign fillHere = stb.fill && (stb.slot == SLOT_W'(g));

    // tag and payload, no reset needed
    always_ff @(posedge clk) begin
      if (fillHere) begin
        entVpn[g]   <= wrVpn;
        entAsid[g]  <= wrAsid;
        entPpn[g]   <= wrPpn;
        entMask[g]  <= wrMask;
        entDirty[g] <= wrDirty;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entValid[g] <= 1'b0;
        entRef[g]   <= 1'b0;
      end else if (stb.clear) begin
        entValid[g] <= 1'b0;
        entRef[g]   <= 1'b0;
      end else if (fillHere) begin
        entValid[g] <= wrValid;
        entRef[g]   <= 1'b0;
      end else if (stb.look && hitNow && (hitIdx == IDX_W'(g))) begin
        entRef[g]   <= 1'b1;
      end
    end

    // offset bits covered by the page size drop out of the compare
    assign cmpMask[g]  = ~{{(VPN_W-MASK_W){1'b0}}, entMask[g]};
    assign matchVec[g] = entValid[g] && (entAsid[g] == lkAsid) &&
                         (((entVpn[g] ^ vaVpn) & cmpMask[g]) == '0);
    assign validVec[g] = entValid[g];
    assign refVec[g]   = entRef[g];
  end

  // lowest-numbered match wins
  always_comb begin
    hitIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) hitIdx = IDX_W'(i);
    end
  end

  assign anyMatch   = |matchVec;
  assign manyMatch  = (matchVec & (matchVec - 1'b1)) != '0;
  assign cleanWrite = lkWrite && !entDirty[hitIdx];
  assign hitNow     = anyMatch && !cleanWrite;

  // splice page-size bits of the virtual address into the frame number
  always_comb begin
    logic [PPN_W-1:0]  selPpn;
    logic [MASK_W-1:0] selMask;
    logic [MASK_W-1:0] vaLow;
    selPpn  = entPpn[hitIdx];
    selMask = entMask[hitIdx];
    vaLow   = lkVaddr[PG_SHIFT +: MASK_W];
    paNow   = {selPpn[PPN_W-1:MASK_W],
               (selPpn[MASK_W-1:0] & ~selMask) | (vaLow & selMask),
               lkVaddr[PG_SHIFT-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lkHit      <= 1'b0;
      lkMiss     <= 1'b0;
      lkModExc   <= 1'b0;
      lkMultiHit <= 1'b0;
      lkPaddr    <= '0;
    end else begin
      lkHit      <= stb.look && hitNow;
      lkMiss     <= stb.look && !anyMatch;
      lkModExc   <= stb.look && anyMatch && cleanWrite;
      lkMultiHit <= stb.look && manyMatch;
      if (stb.look) lkPaddr <= paNow;
    end
  end

  assign rdValid = entValid[rdIdx];
  assign rdRef   = entRef[rdIdx];

  // R11
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (validVec == '0));

  // R3
  one_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.look |=> $onehot({lkHit, lkMiss, lkModExc}));

  // R2
  no_idle_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.look |=> !(lkHit || lkMiss || lkModExc || lkMultiHit));

  // R7
  multi_needs_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkMultiHit |-> (lkHit || lkModExc));

  // R5
  ref_after_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.look && hitNow && !stb.clear && !stb.fill) |=> (refVec != '0));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES  = 32,
  parameter int WIRED    = 4,
  parameter int VA_W     = 32,
  parameter int PG_SHIFT = 12,
  parameter int ASID_W   = 8,
  parameter int PPN_W    = 20,
  parameter int MASK_W   = 12,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int VPN_W   = VA_W - PG_SHIFT,
  localparam int PA_W    = PPN_W + PG_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              lkReq,
  input  logic [VA_W-1:0]   lkVaddr,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic              lkWrite,
  output logic              lkHit,
  output logic              lkMiss,
  output logic              lkModExc,
  output logic              lkMultiHit,
  output logic [PA_W-1:0]   lkPaddr,
  input  logic [1:0]        wrCmd,
  input  logic [IDX_W-1:0]  wrIndex,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic [PPN_W-1:0]  wrPpn,
  input  logic [MASK_W-1:0] wrMask,
  input  logic              wrValid,
  input  logic              wrDirty,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              rdValid,
  output logic              rdRef,
  output logic [IDX_W-1:0]  curRandom
);
  xlat_stb_t stb;

  xlat_ctrl #(
    .ENTRIES (ENTRIES),
    .WIRED   (WIRED)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .flush     (flush),
    .lkReq     (lkReq),
    .wrCmd     (wrCmd),
    .wrIndex   (wrIndex),
    .stb       (stb),
    .curRandom (curRandom)
  );

  xlat_store #(
    .ENTRIES  (ENTRIES),
    .VA_W     (VA_W),
    .PG_SHIFT (PG_SHIFT),
    .ASID_W   (ASID_W),
    .PPN_W    (PPN_W),
    .MASK_W   (MASK_W)
  ) store_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .lkVaddr    (lkVaddr),
    .lkAsid     (lkAsid),
    .lkWrite    (lkWrite),
    .wrVpn      (wrVpn),
    .wrAsid     (wrAsid),
    .wrPpn      (wrPpn),
    .wrMask     (wrMask),
    .wrValid    (wrValid),
    .wrDirty    (wrDirty),
    .rdIdx      (rdIdx),
    .rdValid    (rdValid),
    .rdRef      (rdRef),
    .lkHit      (lkHit),
    .lkMiss     (lkMiss),
    .lkModExc   (lkModExc),
    .lkMultiHit (lkMultiHit),
    .lkPaddr    (lkPaddr)
  );
endmodule

// File: tb/xlat_cache_tb.sv
`timescale 1ns/1ps
module xlat_cache_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        lkReq = 1'b0;
  logic [31:0] lkVaddr = '0;
  logic [7:0]  lkAsid = '0;
  logic        lkWrite = 1'b0;
  logic        lkHit, lkMiss, lkModExc, lkMultiHit;
  logic [31:0] lkPaddr;
  logic [1:0]  wrCmd = 2'd0;
  logic [4:0]  wrIndex = '0;
  logic [19:0] wrVpn = '0;
  logic [7:0]  wrAsid = '0;
  logic [19:0] wrPpn = '0;
  logic [11:0] wrMask = '0;
  logic        wrValid = 1'b0;
  logic        wrDirty = 1'b0;
  logic [4:0]  rdIdx = '0;
  logic        rdValid, rdRef;
  logic [4:0]  curRandom;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  xlat_cache dut_i (
    .clk(clk), .rstN(rstN), .flush(flush), .lkReq(lkReq), .lkVaddr(lkVaddr),
    .lkAsid(lkAsid), .lkWrite(lkWrite), .lkHit(lkHit), .lkMiss(lkMiss),
    .lkModExc(lkModExc), .lkMultiHit(lkMultiHit), .lkPaddr(lkPaddr),
    .wrCmd(wrCmd), .wrIndex(wrIndex), .wrVpn(wrVpn), .wrAsid(wrAsid),
    .wrPpn(wrPpn), .wrMask(wrMask), .wrValid(wrValid), .wrDirty(wrDirty),
    .rdIdx(rdIdx), .rdValid(rdValid), .rdRef(rdRef), .curRandom(curRandom)
  );

  // result codes: 0 miss, 1 hit, 2 modify exception
  typedef struct packed {
    logic [31:0] va;
    logic [7:0]  asid;
    logic        wr;
    logic [1:0]  res;
    logic [31:0] pa;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{va:32'h12345678, asid:8'h01, wr:1'b0, res:2'd1, pa:32'hABCDE678}, // R2
    '{va:32'h12345678, asid:8'h02, wr:1'b0, res:2'd0, pa:32'h0},        // R3
    '{va:32'h12346000, asid:8'h01, wr:1'b0, res:2'd0, pa:32'h0},        // R3
    '{va:32'h00400ABC, asid:8'h02, wr:1'b0, res:2'd1, pa:32'h11111ABC}, // R6
    '{va:32'h00400ABC, asid:8'h02, wr:1'b1, res:2'd2, pa:32'h0},        // R6
    '{va:32'h12345FFF, asid:8'h01, wr:1'b1, res:2'd1, pa:32'hABCDEFFF}, // R6
    '{va:32'h7F123456, asid:8'h03, wr:1'b0, res:2'd1, pa:32'h55123456}, // R4
    '{va:32'h7FFFFFFF, asid:8'h03, wr:1'b0, res:2'd1, pa:32'h55FFFFFF}, // R4
    '{va:32'h7E000000, asid:8'h03, wr:1'b0, res:2'd0, pa:32'h0},        // R4
    '{va:32'h2000A123, asid:8'h04, wr:1'b0, res:2'd1, pa:32'h2222A123}, // R4
    '{va:32'h2001A123, asid:8'h04, wr:1'b0, res:2'd0, pa:32'h0}         // R4
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c);
    @(negedge clk);
    wrCmd = c;
    @(posedge clk);
    @(negedge clk);
    wrCmd = 2'd0;
  endtask

  task automatic fill_at(input logic [4:0] slot, input logic [19:0] vpn,
                         input logic [7:0] asid, input logic [19:0] ppn,
                         input logic [11:0] mask, input bit v, input bit d);
    wrIndex = slot; issue(2'd3);
    wrVpn = vpn; wrAsid = asid; wrPpn = ppn; wrMask = mask;
    wrValid = v; wrDirty = d;
    issue(2'd1);
  endtask

  // result sampled at the falling edge after the registering edge
  task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input bit wr,
                        output logic [1:0] res, output logic [31:0] pa, output bit multi);
    @(negedge clk);
    lkReq = 1'b1; lkVaddr = va; lkAsid = asid; lkWrite = wr;
    @(posedge clk);
    @(negedge clk);
    lkReq = 1'b0; lkWrite = 1'b0;
    res   = lkHit ? 2'd1 : (lkModExc ? 2'd2 : (lkMiss ? 2'd0 : 2'd3));
    pa    = lkPaddr;
    multi = lkMultiHit;
  endtask

  initial begin
    logic [1:0]  res;
    logic [31:0] pa;
    bit          multi;
    logic [4:0]  rnd;
    logic [4:0]  prevR;
    bit          wrapped;
    bit          allClear;

    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    check(curRandom == 5'd31, "R1 random", {27'b0, curRandom}, 32'd31);
    check(!(lkHit || lkMiss || lkModExc || lkMultiHit), "R1 flags",
          {28'b0, lkHit, lkMiss, lkModExc, lkMultiHit}, 32'd0);
    allClear = 1;
    for (int i = 0; i < 32; i++) begin
      rdIdx = 5'(i); #0.1;
      if (rdValid) allClear = 0;
    end
    check(allClear, "R1 valid", {31'b0, allClear}, 32'd1);

    fill_at(5'd0, 20'h12345, 8'h01, 20'hABCDE, 12'h000, 1, 1);
    fill_at(5'd1, 20'h00400, 8'h02, 20'h11111, 12'h000, 1, 0);
    fill_at(5'd2, 20'h7F000, 8'h03, 20'h55000, 12'hFFF, 1, 1);
    fill_at(5'd3, 20'h20000, 8'h04, 20'h22222, 12'h00F, 1, 1);

    rdIdx = 5'd0; #0.1;
    check(rdRef == 1'b0, "R12 ref clear after fill", {31'b0, rdRef}, 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      lookup(VECS[v].va, VECS[v].asid, VECS[v].wr, res, pa, multi);
      check(res == VECS[v].res, "R2/R3/R4/R6 result", {30'b0, res}, {30'b0, VECS[v].res});
      if (VECS[v].res == 2'd1)
        check(pa == VECS[v].pa, "R2/R4 paddr", pa, VECS[v].pa);
      check(multi == 1'b0, "R7 no multi", {31'b0, multi}, 32'd0);
    end

    // R5: hit slots now referenced
    rdIdx = 5'd0; #0.1;
    check(rdRef == 1'b1, "R5 ref slot0", {31'b0, rdRef}, 32'd1);
    rdIdx = 5'd2; #0.1;
    check(rdRef == 1'b1, "R5 ref slot2", {31'b0, rdRef}, 32'd1);

    // R6: clean write does not mark the slot; refill clears ref (R12)
    fill_at(5'd1, 20'h00400, 8'h02, 20'h11111, 12'h000, 1, 0);
    lookup(32'h00400000, 8'h02, 1'b1, res, pa, multi);
    check(res == 2'd2, "R6 mod exc", {30'b0, res}, 32'd2);
    rdIdx = 5'd1; #0.1;
    check(rdRef == 1'b0, "R6 no ref on exc", {31'b0, rdRef}, 32'd0);

    fill_at(5'd0, 20'h12345, 8'h01, 20'hABCDE, 12'h000, 1, 1);
    rdIdx = 5'd0; #0.1;
    check(rdRef == 1'b0, "R12 ref cleared on refill", {31'b0, rdRef}, 32'd0);

    // R7: duplicate in slot 5, slot 0 must win
    fill_at(5'd5, 20'h12345, 8'h01, 20'h99999, 12'h000, 1, 1);
    lookup(32'h12345678, 8'h01, 1'b0, res, pa, multi);
    check(res == 2'd1, "R7 hit", {30'b0, res}, 32'd1);
    check(pa == 32'hABCDE678, "R7 lowest wins", pa, 32'hABCDE678);
    check(multi == 1'b1, "R7 multi flag", {31'b0, multi}, 32'd1);

    // R2: invalid slot never hits
    fill_at(5'd6, 20'h0ABCD, 8'h09, 20'h77777, 12'h000, 0, 1);
    lookup(32'h0ABCD000, 8'h09, 1'b0, res, pa, multi);
    check(res == 2'd0, "R2 invalid slot misses", {30'b0, res}, 32'd0);

    // R8: index register picks the slot
    fill_at(5'd9, 20'h0BEEF, 8'h0A, 20'h0CAFE, 12'h000, 1, 1);
    rdIdx = 5'd9; #0.1;
    check(rdValid == 1'b1, "R8 indexed slot valid", {31'b0, rdValid}, 32'd1);
    rdIdx = 5'd8; #0.1;
    check(rdValid == 1'b0, "R8 neighbour untouched", {31'b0, rdValid}, 32'd0);

    // R9: write-random lands on the shown slot
    @(negedge clk);
    rnd = curRandom;
    wrVpn = 20'h33333; wrAsid = 8'h07; wrPpn = 20'h44444; wrMask = 12'h000;
    wrValid = 1; wrDirty = 1; wrCmd = 2'd2;
    @(posedge clk);
    @(negedge clk);
    wrCmd = 2'd0;
    rdIdx = rnd; #0.1;
    check(rdValid == 1'b1, "R9 random slot valid", {31'b0, rdValid}, 32'd1);
    check(rnd >= 5'd4, "R9 random above wired", {27'b0, rnd}, 32'd4);
    lookup(32'h33333ABC, 8'h07, 1'b0, res, pa, multi);
    check(res == 2'd1 && pa == 32'h44444ABC, "R9 random lookup", pa, 32'h44444ABC);

    // R10: countdown and wrap
    @(negedge clk);
    prevR = curRandom;
    wrapped = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      check(curRandom == ((prevR == 5'd4) ? 5'd31 : prevR - 5'd1), "R10 step",
            {27'b0, curRandom}, {27'b0, ((prevR == 5'd4) ? 5'd31 : prevR - 5'd1)});
      if (prevR == 5'd4) wrapped = 1;
      prevR = curRandom;
    end
    check(wrapped, "R10 wrap seen", {31'b0, wrapped}, 32'd1);

    // R11: flush beats a same-cycle fill
    @(negedge clk);
    flush = 1'b1;
    wrIndex = 5'd12;
    wrCmd = 2'd3;
    @(posedge clk);
    @(negedge clk);
    wrVpn = 20'h01010; wrAsid = 8'h01; wrValid = 1; wrCmd = 2'd1;
    @(posedge clk);
    @(negedge clk);
    flush = 1'b0; wrCmd = 2'd0;
    allClear = 1;
    for (int i = 0; i < 32; i++) begin
      rdIdx = 5'(i); #0.1;
      if (rdValid) allClear = 0;
    end
    check(allClear, "R11 all invalid", {31'b0, allClear}, 32'd1);
    lookup(32'h12345678, 8'h01, 1'b0, res, pa, multi);
    check(res == 2'd0, "R11 miss after flush", {30'b0, res}, 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule